// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a forward-mapped page table in memory. The logical address is cut into a 12-bit outer index, a 10-bit inner index and a 10-bit page offset, so pages are 1 KB. On a request the walker compares the outer index with the table length that comes with the request. If the index is in range, it reads the outer entry at the table base. That entry gives the base of an inner table. The walker then reads the inner entry, and the frame in that entry is joined with the untouched offset to form the physical address.

Each table entry is 32 bits wide. Bit 0 is the valid flag, and bits 31:10 hold a frame number whose base address is the frame number shifted left by 10. A walk stops with a coded fault in three cases: the index is out of range, the outer entry is invalid, or the inner entry is invalid. The trap handler reads the code to tell these apart.

Reads go out on a simple port. The walker holds a request until it is granted and then waits any number of cycles for the returned data. The walker takes one walk at a time and answers each walk with a single-cycle response.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1 and both mem_req and rsp_valid are 0.
- R2: A request is taken only on a cycle where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the response cycle, inclusive. Changes on req_valid, req_vaddr, req_base or req_len while busy have no effect on the walk in progress.
- R3: If the outer index (req_vaddr[31:20]) is equal to or greater than req_len, the walk does no memory read. It answers with rsp_fault=1 and rsp_code=1 in the cycle right after acceptance. This includes the case req_len=0.
- R4: The first read goes to req_base + 4 × outer index. mem_req and mem_addr stay steady until the cycle in which mem_gnt is 1.
- R5: If bit 0 of the outer entry is 0, the walk ends with rsp_fault=1 and rsp_code=2. It issues no second read.
- R6: The second read goes to {outer_entry[31:10], 10'b0} + 4 × inner index, where the inner index is req_vaddr[19:10].
- R7: If bit 0 of the inner entry is 0, the walk ends with rsp_fault=1 and rsp_code=3.
- R8: On success, rsp_fault=0, rsp_code=0 and rsp_paddr = {inner_entry[31:10], req_vaddr[9:0]}. On any fault, rsp_paddr is 0.
- R9: Whatever the grant delay and read latency, every accepted walk gives exactly one response. rsp_valid stays high for one cycle only, and the walker is idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Logical address to translate |
| req_base | input | 32 | Outer table base address |
| req_len | input | 13 | Number of outer table entries |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Read address of the entry |
| mem_gnt | input | 1 | Read request accepted this cycle |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Returned entry |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_code | output | 2 | 0 ok, 1 range, 2 outer invalid, 3 inner invalid |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The assertions assume that the memory side follows the protocol. mem_gnt is raised only while mem_req is high. Each grant is answered by exactly one mem_rvalid pulse, and mem_rvalid never arrives without an outstanding granted read. The bench memory model is written to match. It grants only a pending request, after a random 0 to 2 cycle delay. It then returns one data beat 1 to 4 cycles later, looked up from a sparse table. The bench changes the request inputs while a walk is busy only in order to show that they are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LEN   = 2'd1,
    FLT_OUTER = 2'd2,
    FLT_INNER = 2'd3
  } ptw_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OREQ  = 3'd1,
    ST_OWAIT = 3'd2,
    ST_IREQ  = 3'd3,
    ST_IWAIT = 3'd4,
    ST_RESP  = 3'd5
  } ptw_state_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int OUT_W  = 12,
  parameter int IN_W   = 10,
  parameter int OFF_W  = 10,
  parameter int PA_W   = 32,
  parameter int ENT_SH = 2,
  parameter int VA_W   = OUT_W + IN_W + OFF_W,
  parameter int LEN_W  = OUT_W + 1
) (
  input  logic [VA_W-1:0]  chk_vaddr,
  input  logic [LEN_W-1:0] chk_len,
  output logic             len_ok,
  input  logic [VA_W-1:0]  walk_vaddr,
  input  logic [PA_W-1:0]  outer_base,
  input  logic [PA_W-1:0]  inner_base,
  input  logic             sel_inner,
  output logic [PA_W-1:0]  ent_addr,
  output logic [OFF_W-1:0] pg_off
);

  logic [OUT_W-1:0] chk_outer;
  logic [OUT_W-1:0] w_outer;
  logic [IN_W-1:0]  w_inner;
  logic [PA_W-1:0]  outer_step;
  logic [PA_W-1:0]  inner_step;
  logic [PA_W-1:0]  sel_base;
  logic [PA_W-1:0]  sel_step;

  // Range check works on the live request so a fault needs no read
  assign chk_outer = chk_vaddr[VA_W-1 -: OUT_W];
  assign len_ok    = {1'b0, chk_outer} < chk_len;

  // Index fields of the captured address
  assign w_outer = walk_vaddr[VA_W-1 -: OUT_W];
  assign w_inner = walk_vaddr[OFF_W +: IN_W];
  assign pg_off  = walk_vaddr[OFF_W-1:0];

  assign outer_step = PA_W'(w_outer) << ENT_SH;
  assign inner_step = PA_W'(w_inner) << ENT_SH;

  // One adder shared by both levels
  assign sel_base = sel_inner ? inner_base : outer_base;
  assign sel_step = sel_inner ? inner_step : outer_step;
  assign ent_addr = sel_base + sel_step;

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32,
  parameter int OFF_W = 10,
  parameter int V_BIT = 0,
  parameter int FRM_W = PTE_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  req_base,
  input  logic             len_ok,
  output logic             req_ready,
  output logic             mem_req,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic [VA_W-1:0]  walk_vaddr,
  output logic [PA_W-1:0]  outer_base,
  output logic [PA_W-1:0]  inner_base,
  output logic             sel_inner,
  output logic             done_set,
  output ptw_fault_e       done_code,
  output logic [FRM_W-1:0] done_frame
);

  ptw_state_e      state_q, state_d;
  logic            ld_req;
  logic            ld_itbl;
  logic [VA_W-1:0] vaddr_q;
  logic [PA_W-1:0] base_q;
  logic [PA_W-1:0] itbl_q;

  always_comb begin
    state_d    = state_q;
    mem_req    = 1'b0;
    sel_inner  = 1'b0;
    done_set   = 1'b0;
    done_code  = FLT_NONE;
    done_frame = '0;
    ld_req     = 1'b0;
    ld_itbl    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          if (len_ok) begin
            state_d = ST_OREQ;
          end else begin
            state_d   = ST_RESP;
            done_set  = 1'b1;
            done_code = FLT_LEN;
          end
        end
      end
      ST_OREQ: begin
        mem_req = 1'b1;
        if (mem_gnt) state_d = ST_OWAIT;
      end
      ST_OWAIT: begin
        if (mem_rvalid) begin
          if (mem_rdata[V_BIT]) begin
            ld_itbl = 1'b1;
            state_d = ST_IREQ;
          end else begin
            state_d   = ST_RESP;
            done_set  = 1'b1;
            done_code = FLT_OUTER;
          end
        end
      end
      ST_IREQ: begin
        mem_req   = 1'b1;
        sel_inner = 1'b1;
        if (mem_gnt) state_d = ST_IWAIT;
      end
      ST_IWAIT: begin
        sel_inner = 1'b1;
        if (mem_rvalid) begin
          state_d  = ST_RESP;
          done_set = 1'b1;
          if (mem_rdata[V_BIT]) done_frame = mem_rdata[PTE_W-1:OFF_W];
          else                  done_code  = FLT_INNER;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      base_q  <= '0;
    end else if (ld_req) begin
      vaddr_q <= req_vaddr;
      base_q  <= req_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       itbl_q <= '0;
    else if (ld_itbl) itbl_q <= {mem_rdata[PTE_W-1:OFF_W], {OFF_W{1'b0}}};
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign walk_vaddr = vaddr_q;
  assign outer_base = base_q;
  assign inner_base = itbl_q;

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req); // R2

endmodule

// File: rtl/ptw_rsp.sv
module ptw_rsp
  import ptw_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int OFF_W = 10,
  parameter int FRM_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_set,
  input  ptw_fault_e       done_code,
  input  logic [FRM_W-1:0] done_frame,
  input  logic [OFF_W-1:0] pg_off,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_paddr
);

  logic            valid_q;
  ptw_fault_e      code_q;
  logic [PA_W-1:0] paddr_q, paddr_d;

  assign paddr_d = (done_code == FLT_NONE) ? {done_frame, pg_off} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= done_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= FLT_NONE;
      paddr_q <= '0;
    end else if (done_set) begin
      code_q  <= done_code;
      paddr_q <= paddr_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_fault = (code_q != FLT_NONE);
  assign rsp_code  = code_q;
  assign rsp_paddr = paddr_q;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int OUT_W = 12,
  parameter int IN_W  = 10,
  parameter int OFF_W = 10,
  parameter int PTE_W = 32,
  parameter int V_BIT = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [OUT_W+IN_W+OFF_W-1:0]         req_vaddr,
  input  logic [PTE_W-1:0]                    req_base,
  input  logic [OUT_W:0]                      req_len,
  output logic                                mem_req,
  output logic [PTE_W-1:0]                    mem_addr,
  input  logic                                mem_gnt,
  input  logic                                mem_rvalid,
  input  logic [PTE_W-1:0]                    mem_rdata,
  output logic                                rsp_valid,
  output logic                                rsp_fault,
  output logic [1:0]                          rsp_code,
  output logic [PTE_W-1:0]                    rsp_paddr
);

  localparam int VA_W   = OUT_W + IN_W + OFF_W;
  localparam int PA_W   = PTE_W;
  localparam int FRM_W  = PTE_W - OFF_W;
  localparam int ENT_SH = $clog2(PTE_W / 8);

  logic             len_ok;
  logic [VA_W-1:0]  walk_vaddr;
  logic [PA_W-1:0]  outer_base;
  logic [PA_W-1:0]  inner_base;
  logic             sel_inner;
  logic [OFF_W-1:0] pg_off;
  logic             done_set;
  ptw_fault_e       done_code;
  logic [FRM_W-1:0] done_frame;

  ptw_addr_gen #(
    .OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W), .PA_W(PA_W), .ENT_SH(ENT_SH)
  ) u_addr (
    .chk_vaddr  (req_vaddr),
    .chk_len    (req_len),
    .len_ok     (len_ok),
    .walk_vaddr (walk_vaddr),
    .outer_base (outer_base),
    .inner_base (inner_base),
    .sel_inner  (sel_inner),
    .ent_addr   (mem_addr),
    .pg_off     (pg_off)
  );

  ptw_fsm #(
    .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .OFF_W(OFF_W), .V_BIT(V_BIT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_base   (req_base),
    .len_ok     (len_ok),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .walk_vaddr (walk_vaddr),
    .outer_base (outer_base),
    .inner_base (inner_base),
    .sel_inner  (sel_inner),
    .done_set   (done_set),
    .done_code  (done_code),
    .done_frame (done_frame)
  );

  ptw_rsp #(
    .PA_W(PA_W), .OFF_W(OFF_W)
  ) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_set   (done_set),
    .done_code  (done_code),
    .done_frame (done_frame),
    .pg_off     (pg_off),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_code   (rsp_code),
    .rsp_paddr  (rsp_paddr)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R4

  AST_LEN_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !len_ok) |=> (rsp_valid && rsp_code == 2'd1 && !mem_req)); // R3

  AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R2

  AST_MEM_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rsp_valid); // R9

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [31:0] req_base;
  logic [12:0] req_len;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_base(req_base), .req_len(req_len),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int grants = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr [$];
  string       exp_tag  [$];

  localparam logic [31:0] OBASE = 32'h0004_0000;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] itbl(input int o);
    return 32'h0010_0000 + o * 32'h1000;
  endfunction

  // Reference walk: follows the requirements on the bench's own memory copy
  task automatic ref_walk(input logic [31:0] va, input logic [31:0] base,
                          input logic [12:0] len, output logic [1:0] code,
                          output logic [31:0] pa);
    logic [31:0] a1, a2, e1, e2;
    int o, i;
    o = int'(va[31:20]);
    i = int'(va[19:10]);
    pa = 32'h0;
    if (o >= int'(len)) begin
      code = 2'd1;
    end else begin
      a1 = base + 32'(o * 4);
      exp_addr.push_back(a1); exp_tag.push_back("R4");
      e1 = rd(a1);
      if (!e1[0]) begin
        code = 2'd2;
      end else begin
        a2 = {e1[31:10], 10'b0} + 32'(i * 4);
        exp_addr.push_back(a2); exp_tag.push_back("R6");
        e2 = rd(a2);
        if (!e2[0]) code = 2'd3;
        else begin
          code = 2'd0;
          pa = {e2[31:10], va[9:0]};
        end
      end
    end
  endtask

  // Memory model: random grant delay, random read latency, one beat per grant
  initial begin
    logic [31:0] pend_addr;
    bit pend;
    int lat, gdly;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = 32'h0;
    pend = 1'b0; lat = 0; gdly = 0; pend_addr = 32'h0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_gnt) begin
        mem_gnt = 1'b0;
        pend = 1'b1;
        lat = int'($urandom % 4);
      end else if (pend) begin
        if (lat == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd(pend_addr);
          pend = 1'b0;
        end else lat--;
      end else if (mem_req === 1'b1) begin
        if (gdly == 0) begin
          mem_gnt = 1'b1;
          pend_addr = mem_addr;
          grants++;
          if (exp_addr.size() == 0) begin
            chk(1'b0, "R5", "unexpected read", mem_addr, 32'h0);
          end else begin
            string t;
            logic [31:0] ea;
            ea = exp_addr.pop_front();
            t  = exp_tag.pop_front();
            chk(mem_addr == ea, t, "entry read address", mem_addr, ea);
          end
          gdly = int'($urandom % 3);
        end else gdly--;
      end
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic [31:0] base,
                          input logic [12:0] len, input bit junk);
    logic [1:0]  ecode;
    logic [31:0] epa;
    int g0, cyc;
    ref_walk(va, base, len, ecode, epa);
    g0 = grants;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", 32'(req_ready), 32'h1);
    req_valid = 1'b1; req_vaddr = va; req_base = base; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (rsp_valid !== 1'b1 && cyc < 200) begin
      chk(req_ready == 1'b0, "R2", "busy during walk", 32'(req_ready), 32'h0);
      if (junk && cyc == 2) begin
        req_valid = 1'b1; req_vaddr = ~va; req_base = 32'hDEAD_0000; req_len = 13'd0;
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R9", "response arrived", 32'(cyc), 32'h0);
    chk(rsp_code == ecode, ecode == 2'd1 ? "R3" : ecode == 2'd2 ? "R5" :
        ecode == 2'd3 ? "R7" : "R8", "fault code", 32'(rsp_code), 32'(ecode));
    chk(rsp_fault == (ecode != 2'd0), "R8", "fault flag", 32'(rsp_fault), 32'(ecode != 2'd0));
    chk(rsp_paddr == epa, "R8", "physical address", rsp_paddr, epa);
    if (ecode == 2'd1) begin
      chk(cyc == 1, "R3", "range fault latency", 32'(cyc), 32'h1);
      chk(grants == g0, "R3", "reads on range fault", 32'(grants - g0), 32'h0);
    end
    if (ecode == 2'd2)
      chk(grants == g0 + 1, "R5", "reads on outer fault", 32'(grants - g0), 32'h1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "single cycle response", 32'(rsp_valid), 32'h0);
    chk(req_ready == 1'b1, "R2", "idle after response", 32'(req_ready), 32'h1);
    chk(exp_addr.size() == 0, "R6", "all reads issued", 32'(exp_addr.size()), 32'h0);
    exp_addr.delete(); exp_tag.delete();
  endtask

  task automatic set_outer(input int o, input bit v);
    mem[OBASE + 32'(o * 4)] = {itbl(o)[31:10], 9'h0AA, v};
  endtask

  task automatic set_inner(input int o, input int i, input logic [21:0] frm, input bit v);
    mem[itbl(o) + 32'(i * 4)] = {frm, 9'h155, v};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = 32'h0; req_base = 32'h0; req_len = 13'h0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'h1);
    chk(mem_req == 1'b0, "R1", "no read in reset", 32'(mem_req), 32'h0);
    chk(rsp_valid == 1'b0, "R1", "no response in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0 && rsp_valid == 1'b0, "R1",
        "idle after reset", {29'h0, req_ready, mem_req, rsp_valid}, 32'h4);

    // R8 plain success with all-ones offset
    set_outer(3, 1'b1); set_inner(3, 7, 22'h12345, 1'b1);
    run_walk({12'd3, 10'd7, 10'h3FF}, OBASE, 13'd16, 1'b0);
    // R8 last in-range index, zero offset
    set_outer(15, 1'b1); set_inner(15, 1023, 22'h3FFFFF, 1'b1);
    run_walk({12'd15, 10'd1023, 10'h000}, OBASE, 13'd16, 1'b0);
    // R3 index equal to length, and zero length
    run_walk({12'd16, 10'd0, 10'h001}, OBASE, 13'd16, 1'b0);
    run_walk({12'd0, 10'd0, 10'h001}, OBASE, 13'd0, 1'b0);
    // R5 outer entry invalid
    set_outer(4, 1'b0);
    run_walk({12'd4, 10'd2, 10'h010}, OBASE, 13'd16, 1'b0);
    // R7 inner entry invalid
    set_outer(5, 1'b1); set_inner(5, 9, 22'h0ABCD, 1'b0);
    run_walk({12'd5, 10'd9, 10'h020}, OBASE, 13'd16, 1'b0);
    // R2 inputs changed while busy are ignored
    run_walk({12'd3, 10'd7, 10'h155}, OBASE, 13'd16, 1'b1);
    // R6 two pages behind the same outer entry
    set_inner(3, 8, 22'h00777, 1'b1);
    run_walk({12'd3, 10'd8, 10'h2A0}, OBASE, 13'd16, 1'b0);

    // R9 random walks across all outcomes and latencies
    for (int n = 0; n < 40; n++) begin
      int o, i;
      o = int'($urandom % 22);
      i = int'($urandom % 1024);
      if (!mem.exists(OBASE + 32'(o * 4))) set_outer(o, 1'($urandom % 4 != 0));
      if (!mem.exists(itbl(o) + 32'(i * 4)) && ($urandom % 3 != 0))
        set_inner(o, i, 22'($urandom), 1'($urandom % 4 != 0));
      run_walk({12'(o), 10'(i), 10'($urandom)}, OBASE, 13'd20, 1'($urandom % 2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule